// File: doc/BRIEF.md
# Serial Break Start/End Detector

This block watches a serial receive line that is already synchronized to the system clock and sampled on a 16x tick. It reports when the line enters a break, meaning it stays low for longer than one full character frame. It also reports when the break ends. The two edges give two separate one-cycle events, and each event also sets its own sticky flag. A host clears a flag by writing a one to it, so a consumer can tell which edge happened even if both arrived before it serviced either.

The same logic qualifies the start of a packet. A break counts as a valid packet lead-in only if it holds low for at least two character times. The line must then stay high for at least one bit time. When both conditions are met, the block pulses packet start in the same cycle as the end-of-break event.

All durations are counted in sample ticks. The bit length (ticks per bit, normally 16) and the character length (bits per character, normally 10) are inputs. A high blip shorter than one bit time inside a break is a glitch. It does not end the break, but it does set a glitch flag.

Top module: `serial_break_monitor`

## Requirements
- R1: With C = char_bits_i × bit_ticks_i, brk_start_o pulses on the clock after the (C+1)-th consecutive low tick. A low run of C ticks or fewer, followed by a high tick, gives no start event.
- R2: After a break, brk_end_o pulses on the clock after the bit_ticks_i-th consecutive high tick. The block then returns to idle.
- R3: Inside a break, a high run shorter than bit_ticks_i ticks that is followed by a low tick gives no end event and sets glitch_flag_o. The break keeps its accumulated low-tick count; high ticks are not added to it.
- R4: pkt_start_o pulses in the same cycle as brk_end_o only when the break held at least 2×C low ticks. A break of 2×C−1 low ticks gives none.
- R5: If the mark after a long break is cut short by a low tick, no packet start is given. A later full-bit-time mark still qualifies it.
- R6: brk_start_o, brk_end_o and pkt_start_o are single-cycle pulses. Each appears on the clock edge that samples the deciding tick.
- R7: Sticky flags map to flag_clr_i as follows: bit 0 clears start_flag_o, bit 1 clears end_flag_o, bit 2 clears glitch_flag_o. A set in the same cycle as a clear wins. The start and end flags latch independently, so both can be 1 together.
- R8: While tick_i is 0, rx_i has no effect on any state.
- R9: After reset all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 16x sample enable, one cycle wide |
| rx_i | input | 1 | Synchronized receive line, 1 = mark |
| char_bits_i | input | 4 | Bits per character frame (at least 1) |
| bit_ticks_i | input | 5 | Sample ticks per bit (at least 1) |
| flag_clr_i | input | 3 | Write-one-to-clear strobes for the sticky flags |
| brk_start_o | output | 1 | Start-of-break pulse |
| brk_end_o | output | 1 | End-of-break pulse |
| pkt_start_o | output | 1 | Packet-start pulse |
| start_flag_o | output | 1 | Sticky start-of-break flag |
| end_flag_o | output | 1 | Sticky end-of-break flag |
| glitch_flag_o | output | 1 | Sticky glitch-seen flag |

## Verification
The assertions assume that char_bits_i and bit_ticks_i are nonzero and stay constant while a break is being measured. They also assume rx_i is already synchronized, so it changes only between clock edges. The stimulus sets the lengths only while reset is held or the line is idle. It changes rx_i and tick_i on the falling clock edge and keeps both lengths at least 1, so a single low tick can never count as a whole frame.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_BREAK = 2'd2,
    ST_MARK  = 2'd3
  } sbm_state_e;

  localparam int unsigned FLAG_START  = 0;
  localparam int unsigned FLAG_END    = 1;
  localparam int unsigned FLAG_GLITCH = 2;
  localparam int unsigned NUM_FLAGS   = 3;
endpackage

// File: rtl/sbm_run_counter.sv
module sbm_run_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (load_i)              cnt_o <= W'(1);
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + W'(1);
  end

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !load_i && cnt_o == MAX) |=> cnt_o == MAX); // R1
endmodule

// File: rtl/sbm_sticky_bank.sv
module sbm_sticky_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[k] <= 1'b0;
      else if (set_i[k]) flag_o[k] <= 1'b1;
      else if (clr_i[k]) flag_o[k] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]); // R7
  end
endmodule

// File: rtl/serial_break_monitor.sv
module serial_break_monitor
  import sbm_pkg::*;
#(
  parameter int unsigned CHAR_W = 4,
  parameter int unsigned BIT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [CHAR_W-1:0] char_bits_i,
  input  logic [BIT_W-1:0]  bit_ticks_i,
  input  logic [2:0]        flag_clr_i,
  output logic              brk_start_o,
  output logic              brk_end_o,
  output logic              pkt_start_o,
  output logic              start_flag_o,
  output logic              end_flag_o,
  output logic              glitch_flag_o
);
  localparam int unsigned CNT_W = CHAR_W + BIT_W + 1;

  sbm_state_e st_q, st_d;
  logic [CNT_W-1:0] lo_cnt, char_ticks;
  logic [CNT_W:0]   valid_ticks;
  logic [BIT_W-1:0] hi_cnt;
  logic lo_clr, lo_load, lo_inc, hi_clr, hi_load, hi_inc;
  logic start_ev, end_ev, pkt_ev, glitch_ev, fin, long_break;
  logic [NUM_FLAGS-1:0] flag_set, flag_q;

  assign char_ticks  = CNT_W'(char_bits_i) * CNT_W'(bit_ticks_i);
  assign valid_ticks = {char_ticks, 1'b0};
  assign long_break  = {1'b0, lo_cnt} >= valid_ticks;

  sbm_run_counter #(.W(CNT_W)) i_low_run (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (lo_clr), .load_i(lo_load), .inc_i(lo_inc),
    .cnt_o (lo_cnt)
  );

  sbm_run_counter #(.W(BIT_W)) i_high_run (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (hi_clr), .load_i(hi_load), .inc_i(hi_inc),
    .cnt_o (hi_cnt)
  );

  always_comb begin
    st_d      = st_q;
    lo_clr    = 1'b0;
    lo_load   = 1'b0;
    lo_inc    = 1'b0;
    hi_clr    = 1'b0;
    hi_load   = 1'b0;
    hi_inc    = 1'b0;
    start_ev  = 1'b0;
    glitch_ev = 1'b0;
    fin       = 1'b0;
    if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!rx_i) begin
            lo_load = 1'b1;
            st_d    = ST_LOW;
          end
        end
        ST_LOW: begin
          if (rx_i) begin
            lo_clr = 1'b1;          // just a character
            st_d   = ST_IDLE;
          end else begin
            lo_inc = 1'b1;
            if (lo_cnt == char_ticks) begin
              start_ev = 1'b1;
              st_d     = ST_BREAK;
            end
          end
        end
        ST_BREAK: begin
          if (rx_i) begin
            if (bit_ticks_i <= BIT_W'(1)) fin = 1'b1;
            else begin
              hi_load = 1'b1;
              st_d    = ST_MARK;
            end
          end else begin
            lo_inc = 1'b1;
          end
        end
        ST_MARK: begin
          if (rx_i) begin
            if (hi_cnt >= bit_ticks_i - BIT_W'(1)) fin = 1'b1;
            else hi_inc = 1'b1;
          end else begin
            // short mark: glitch, resume break measurement
            hi_clr    = 1'b1;
            glitch_ev = 1'b1;
            lo_inc    = 1'b1;
            st_d      = ST_BREAK;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    end_ev = fin;
    pkt_ev = fin && long_break;
    if (fin) begin
      lo_clr = 1'b1;
      hi_clr = 1'b1;
      st_d   = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      brk_start_o <= 1'b0;
      brk_end_o   <= 1'b0;
      pkt_start_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      brk_start_o <= start_ev;
      brk_end_o   <= end_ev;
      pkt_start_o <= pkt_ev;
    end
  end

  always_comb begin
    flag_set              = '0;
    flag_set[FLAG_START]  = start_ev;
    flag_set[FLAG_END]    = end_ev;
    flag_set[FLAG_GLITCH] = glitch_ev;
  end

  sbm_sticky_bank #(.N(NUM_FLAGS)) i_flags (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (flag_set), .clr_i(flag_clr_i),
    .flag_o(flag_q)
  );

  assign start_flag_o  = flag_q[FLAG_START];
  assign end_flag_o    = flag_q[FLAG_END];
  assign glitch_flag_o = flag_q[FLAG_GLITCH];

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_start_o |=> !brk_start_o); // R6
  AST_END_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_end_o |=> !brk_end_o); // R6
  AST_PKT_WITH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> brk_end_o); // R4
  AST_START_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_start_o |-> start_flag_o); // R7
  AST_END_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_end_o |-> end_flag_o); // R7
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(st_q)); // R8
  AST_NO_TICK_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !(brk_start_o || brk_end_o)); // R8
endmodule

// File: tb/test_serial_break_monitor.sv
module test_serial_break_monitor;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic [3:0] char_bits_i = 4'd4;
  logic [4:0] bit_ticks_i = 5'd4;
  logic [2:0] flag_clr_i = 3'b000;
  logic brk_start_o, brk_end_o, pkt_start_o;
  logic start_flag_o, end_flag_o, glitch_flag_o;

  int checks = 0, errors = 0;
  int n_start = 0, n_end = 0, n_pkt = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  serial_break_monitor i_serial_break_monitor (
    .clk_i, .rst_ni, .tick_i, .rx_i, .char_bits_i, .bit_ticks_i, .flag_clr_i,
    .brk_start_o, .brk_end_o, .pkt_start_o,
    .start_flag_o, .end_flag_o, .glitch_flag_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic rx, input logic tk = 1'b1, input logic [2:0] clr = 3'b000);
    @(negedge clk_i);
    rx_i = rx; tick_i = tk; flag_clr_i = clr;
    @(posedge clk_i);
    #1;
    n_start += int'(brk_start_o);
    n_end   += int'(brk_end_o);
    n_pkt   += int'(pkt_start_o);
  endtask

  task automatic run(input logic rx, input int n);
    for (int i = 0; i < n; i++) step(rx);
  endtask

  task automatic zero_counts();
    n_start = 0; n_end = 0; n_pkt = 0;
  endtask

  task automatic do_reset(input logic [3:0] cb, input logic [4:0] bt);
    @(negedge clk_i);
    rst_ni = 1'b0; rx_i = 1'b1; tick_i = 1'b0; flag_clr_i = '0;
    char_bits_i = cb; bit_ticks_i = bt;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    zero_counts();
  endtask

  task automatic t_reset();
    do_reset(4'd4, 5'd4);
    #1;
    chk({brk_start_o, brk_end_o, pkt_start_o, start_flag_o, end_flag_o, glitch_flag_o} == 6'b0,
        "R9 outputs after reset", int'({brk_start_o, brk_end_o, pkt_start_o,
        start_flag_o, end_flag_o, glitch_flag_o}), 0);
  endtask

  task automatic t_character_run();
    do_reset(4'd4, 5'd4);           // C = 16
    run(1'b0, 16);
    run(1'b1, 8);
    chk(n_start == 0, "R1 low run of C ticks gives no start", n_start, 0);
    chk(start_flag_o == 1'b0, "R1 no start flag after character", start_flag_o, 0);
  endtask

  task automatic t_break_basic();
    do_reset(4'd4, 5'd4);
    run(1'b0, 16);
    chk(n_start == 0, "R1 no start before C+1 low ticks", n_start, 0);
    step(1'b0);
    chk(brk_start_o == 1'b1, "R1 start on C+1 low tick", brk_start_o, 1);
    step(1'b0);
    chk(brk_start_o == 1'b0, "R6 start is one cycle", brk_start_o, 0);
    zero_counts();
    run(1'b1, 3);
    chk(n_end == 0, "R2 no end before bit time high", n_end, 0);
    step(1'b1);
    chk(brk_end_o == 1'b1, "R2 end on bit_ticks-th high tick", brk_end_o, 1);
    chk(pkt_start_o == 1'b0, "R4 short break gives no packet start", pkt_start_o, 0);
    chk(start_flag_o && end_flag_o, "R7 both flags latched", int'({start_flag_o, end_flag_o}), 3);
    step(1'b1);
    chk(brk_end_o == 1'b0, "R6 end is one cycle", brk_end_o, 0);
    step(1'b1, 1'b1, 3'b011);
    chk({start_flag_o, end_flag_o} == 2'b00, "R7 write-one clears", int'({start_flag_o, end_flag_o}), 0);
  endtask

  task automatic t_glitch_boundary();
    do_reset(4'd4, 5'd4);           // 2C = 32
    run(1'b0, 20);
    zero_counts();
    run(1'b1, 3);
    step(1'b0);                     // 21 low ticks
    chk(n_end == 0, "R3 short high gives no end", n_end, 0);
    chk(glitch_flag_o == 1'b1, "R3 glitch flag set", glitch_flag_o, 1);
    run(1'b0, 10);                  // 31 low ticks
    run(1'b1, 4);
    chk(n_end == 1, "R2 end after glitch break", n_end, 1);
    chk(n_pkt == 0, "R4 2C-1 low ticks gives no packet start", n_pkt, 0);
    chk(n_start == 0, "R3 glitch did not restart break", n_start, 0);
  endtask

  task automatic t_packet();
    do_reset(4'd4, 5'd4);
    run(1'b0, 32);
    zero_counts();
    run(1'b1, 3);
    chk(n_pkt == 0, "R4 no packet start before mark done", n_pkt, 0);
    step(1'b1);
    chk(pkt_start_o && brk_end_o, "R4 packet start with end",
        int'({pkt_start_o, brk_end_o}), 3);
    step(1'b1);
    chk(pkt_start_o == 1'b0, "R6 packet start is one cycle", pkt_start_o, 0);
  endtask

  task automatic t_mab_abort();
    do_reset(4'd4, 5'd4);
    run(1'b0, 32);
    zero_counts();
    run(1'b1, 3);
    step(1'b0);
    chk(n_pkt == 0 && n_end == 0, "R5 short mark aborts", n_pkt + n_end, 0);
    run(1'b1, 4);
    chk(n_pkt == 1, "R5 later full mark qualifies", n_pkt, 1);
  endtask

  task automatic t_set_beats_clear();
    do_reset(4'd4, 5'd4);
    run(1'b0, 16);
    step(1'b0, 1'b1, 3'b001);       // start event and clear together
    chk(start_flag_o == 1'b1, "R7 set wins over clear", start_flag_o, 1);
    step(1'b0, 1'b1, 3'b001);
    chk(start_flag_o == 1'b0, "R7 later clear works", start_flag_o, 0);
  endtask

  task automatic t_tick_gate();
    do_reset(4'd4, 5'd4);
    run(1'b0, 10);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    run(1'b0, 6);                   // 16 low ticks
    chk(n_start == 0, "R8 gated cycles do not count", n_start, 0);
    step(1'b0);
    chk(brk_start_o == 1'b1, "R8 start after 17 real ticks", brk_start_o, 1);
  endtask

  task automatic t_default_lengths();
    do_reset(4'd10, 5'd16);         // C = 160
    run(1'b0, 160);
    chk(n_start == 0, "R1 default no start at 160", n_start, 0);
    step(1'b0);
    chk(brk_start_o == 1'b1, "R1 default start at 161", brk_start_o, 1);
    run(1'b0, 159);                 // 320 low ticks
    zero_counts();
    run(1'b1, 16);
    chk(n_pkt == 1 && n_end == 1, "R4 default packet start", n_pkt * 10 + n_end, 11);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_character_run();
    t_break_basic();
    t_glitch_boundary();
    t_packet();
    t_mab_abort();
    t_set_beats_clear();
    t_tick_gate();
    t_default_lengths();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule